// File: doc/BRIEF.md
# Delayed Clock-Select Output Multiplexer

This block decides which clock drives the video clock pin and the memory clock pin of a programmable dual-clock generator. It does not make any clocks itself. It receives three synthesized video clocks, an external clock, the reference clock, the memory clock and a slow power-down clock, and it routes one of them to each pin. Every handover goes through a break-before-make switch, so neither pin ever carries a shortened pulse.

The two select pins also carry serial programming traffic. For this reason a new select code does not take effect at once. The pins must stay unchanged for a full time-out window. When that window expires, the new video source is committed. A second window of the same length then gives the new synthesizer time to settle. During this second window a stand-in clock drives the video pin. A control input chooses the stand-in: the reference clock or the memory clock. A pulse saying that the active video register was rewritten triggers both windows with the stand-in in place. A matching pulse does the same for the memory pin, where the stand-in is always the reference clock. A control input doubles the window length. Output-enable and power-down inputs act on both pins.

Top module: `clock_output_router`

## Requirements
- R1: While reset is held, both clock outputs are low. After reset, the video output carries video clock 0 and the memory output carries the memory clock.
- R2: The committed select code `sel_i` = {bit1, bit0} maps as follows: 00 gives video clock 0, 01 gives video clock 1, 11 gives video clock 2. Code 10 gives the external clock when `extsel_i` is 0 and video clock 2 when `extsel_i` is 1.
- R3: A change on `sel_i` takes effect only after the synchronized pins have stayed unchanged for TMO_CYC reference cycles. Until then the previous source stays on the output. If a burst of changes returns to the committed code before the window expires, the output is never disturbed and no stand-in is used.
- R4: After a new code is committed, the stand-in clock drives the video output for a further TMO_CYC reference cycles. The newly selected source follows.
- R5: The stand-in clock is the reference clock when `fb_mclk_i` is 0 and the memory clock when `fb_mclk_i` is 1.
- R6: When `long_tmo_i` is 1, both windows last 2*TMO_CYC reference cycles.
- R7: A one-cycle pulse on `vid_reprog_i` puts the stand-in on the video output for both windows. The same register's clock then returns.
- R8: A one-cycle pulse on `mem_reprog_i` puts the reference clock on the memory output for both windows. The memory clock then returns. The video output is not affected.
- R9: When `oe_i` is low, both pad enables are low and both data outputs are low.
- R10: When `oe_i` is high and `pd_ni` is low, the video output is held high and the memory output carries `pdclk_i`.
- R11: No output pulse is narrower than the shortest half-period among the sources involved. At most one source enable is active at a time in each multiplexer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Asynchronous active-low reset |
| ref_clk_i | input | 1 | Reference clock; also clocks the control logic |
| vclk0_i | input | 1 | Video synthesizer clock, register 0 |
| vclk1_i | input | 1 | Video synthesizer clock, register 1 |
| vclk2_i | input | 1 | Video synthesizer clock, register 2 |
| ext_clk_i | input | 1 | External clock input |
| mclk_src_i | input | 1 | Memory synthesizer clock |
| pdclk_i | input | 1 | Power-down divider clock for the memory pin |
| sel_i | input | 2 | Clock select pins (shared with serial programming) |
| extsel_i | input | 1 | 0 lets code 10 pick the external clock |
| oe_i | input | 1 | Output enable, active high |
| pd_ni | input | 1 | Power-down, active low |
| long_tmo_i | input | 1 | Doubles the time-out windows |
| fb_mclk_i | input | 1 | Stand-in source: 0 reference, 1 memory clock |
| vid_reprog_i | input | 1 | Pulse: active video register rewritten |
| mem_reprog_i | input | 1 | Pulse: memory register rewritten |
| vclk_o | output | 1 | Video clock data |
| vclk_oe_o | output | 1 | Video clock pad enable |
| mclk_o | output | 1 | Memory clock data |
| mclk_oe_o | output | 1 | Memory clock pad enable |

## Verification
The bench identifies the source on each pin by counting edges over windows placed inside each phase. This catches the following faults:
- a select that leaks through before the hold window ends, which shows the new clock too early;
- a missing settle phase, which skips the stand-in;
- a wrong stand-in choice, which shows the wrong edge rate;
- a doubled window that is ignored, which switches at the normal time.

A burst of pin changes that returns to the committed code checks that no stray commit or settle happens. A design that restarts the settle on every pin change would briefly show the stand-in. A pulse-width monitor runs through all switching. It catches an AND-OR multiplexer without break-before-make, which would emit runt pulses at handovers. Power-down and output enable are checked at the pins. A design that gated the wrong output, or muxed the video clock instead of forcing it high, would be caught here.

// File: rtl/clkroute_pkg.sv
package clkroute_pkg;

  // video source indices
  localparam int unsigned VSRC_N  = 6;
  localparam logic [2:0]  VI_R0   = 3'd0;
  localparam logic [2:0]  VI_R1   = 3'd1;
  localparam logic [2:0]  VI_R2   = 3'd2;
  localparam logic [2:0]  VI_EXT  = 3'd3;
  localparam logic [2:0]  VI_REF  = 3'd4;
  localparam logic [2:0]  VI_MCLK = 3'd5;

  // memory source indices
  localparam int unsigned MSRC_N  = 3;
  localparam logic [1:0]  MI_MCLK = 2'd0;
  localparam logic [1:0]  MI_REF  = 2'd1;
  localparam logic [1:0]  MI_PD   = 2'd2;

  typedef enum logic [1:0] {PH_IDLE, PH_HOLD, PH_SETTLE} phase_e;

  // committed select code -> video source
  function automatic logic [2:0] vsel_decode(input logic [1:0] code, input logic extsel);
    case (code)
      2'b00:   return VI_R0;
      2'b01:   return VI_R1;
      2'b11:   return VI_R2;
      default: return extsel ? VI_R2 : VI_EXT;
    endcase
  endfunction

  // window length in reference cycles
  function automatic int unsigned window_len(input int unsigned base, input logic dbl);
    return dbl ? (2 * base) : base;
  endfunction

  // stand-in video source
  function automatic logic [2:0] vfallback(input logic use_mclk);
    return use_mclk ? VI_MCLK : VI_REF;
  endfunction

endpackage

// File: rtl/clkroute_window.sv
module clkroute_window
  import clkroute_pkg::*;
#(
  parameter int unsigned BASE = 4096
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic kick_i,       // (re)start the hold window
  input  logic long_i,       // doubled windows
  input  logic settle_ok_i,  // sampled at hold expiry: run settle window
  output logic hold_o,
  output logic settle_o,
  output logic hold_done_o   // one-cycle pulse when the hold window expires
);

  localparam int unsigned CW = $clog2(2 * BASE + 1);

  phase_e        ph_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim;
  logic          at_end;

  always_comb begin
    lim    = CW'(window_len(BASE, long_i));
    at_end = (cnt_q == lim - 1'b1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else if (kick_i) begin
      ph_q  <= PH_HOLD;
      cnt_q <= '0;
    end else begin
      case (ph_q)
        PH_HOLD: begin
          if (at_end) begin
            ph_q  <= settle_ok_i ? PH_SETTLE : PH_IDLE;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_SETTLE: begin
          if (at_end) begin
            ph_q  <= PH_IDLE;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: cnt_q <= '0;
      endcase
    end
  end

  assign hold_o      = (ph_q == PH_HOLD);
  assign settle_o    = (ph_q == PH_SETTLE);
  assign hold_done_o = hold_o && at_end && !kick_i;

endmodule

// File: rtl/clkroute_bbm_mux.sv
module clkroute_bbm_mux #(
  parameter int unsigned N = 2
) (
  input  logic         rst_ni,
  input  logic [N-1:0] clk_i,
  input  logic [N-1:0] pick_i,   // one-hot request from the control domain
  output logic [N-1:0] en_o,
  output logic         clk_o
);

  logic [N-1:0] busy;

  for (genvar g = 0; g < N; g++) begin : g_src
    logic s1_q, s2_q;
    logic req;

    // take a source only when every other source has fully released
    assign req     = pick_i[g] && ((busy & ~(N'(1) << g)) == '0);
    assign busy[g] = s1_q | s2_q;
    assign en_o[g] = s2_q;

    // enable changes only while this clock is low
    always_ff @(negedge clk_i[g] or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
      end else begin
        s1_q <= req;
        s2_q <= s1_q;
      end
    end
  end

  assign clk_o = |(en_o & clk_i);

endmodule

// File: rtl/clock_output_router.sv
module clock_output_router
  import clkroute_pkg::*;
#(
  parameter int unsigned TMO_CYC = 4096
) (
  input  logic       rst_ni,
  input  logic       ref_clk_i,
  input  logic       vclk0_i,
  input  logic       vclk1_i,
  input  logic       vclk2_i,
  input  logic       ext_clk_i,
  input  logic       mclk_src_i,
  input  logic       pdclk_i,
  input  logic [1:0] sel_i,
  input  logic       extsel_i,
  input  logic       oe_i,
  input  logic       pd_ni,
  input  logic       long_tmo_i,
  input  logic       fb_mclk_i,
  input  logic       vid_reprog_i,
  input  logic       mem_reprog_i,
  output logic       vclk_o,
  output logic       vclk_oe_o,
  output logic       mclk_o,
  output logic       mclk_oe_o
);

  // pin synchronizers in the reference domain
  logic [1:0] sel_s1_q, sel_s2_q;
  logic       ext_s1_q, ext_s2_q;
  logic       pd_s1_q, pd_s2_q;

  always_ff @(posedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_s1_q <= 2'b00;
      sel_s2_q <= 2'b00;
      ext_s1_q <= 1'b0;
      ext_s2_q <= 1'b0;
      pd_s1_q  <= 1'b1;
      pd_s2_q  <= 1'b1;
    end else begin
      sel_s1_q <= sel_i;
      sel_s2_q <= sel_s1_q;
      ext_s1_q <= extsel_i;
      ext_s2_q <= ext_s1_q;
      pd_s1_q  <= pd_ni;
      pd_s2_q  <= pd_s1_q;
    end
  end

  // named internal events
  logic [1:0] v_seen_q;
  logic [1:0] v_active_q;
  logic       v_reprog_q;
  logic       v_kick;
  logic       v_settle_ok;
  logic       v_hold, v_settle, v_commit;
  logic       v_fb;
  logic [2:0] v_idx;
  logic [VSRC_N-1:0] v_pick, v_en, v_srcs;
  logic       v_mux;

  logic       m_hold, m_settle, m_hold_done;
  logic       m_busy;
  logic       pd_sync;
  logic [1:0] m_idx;
  logic [MSRC_N-1:0] m_pick, m_en, m_srcs;
  logic       m_mux;

  assign pd_sync     = pd_s2_q;
  assign v_kick      = (sel_s2_q != v_seen_q) || vid_reprog_i;
  assign v_settle_ok = (v_seen_q != v_active_q) || v_reprog_q;

  always_ff @(posedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_seen_q   <= 2'b00;
      v_active_q <= 2'b00;
      v_reprog_q <= 1'b0;
    end else begin
      v_seen_q <= sel_s2_q;
      if (v_commit)
        v_active_q <= v_seen_q;
      if (vid_reprog_i)
        v_reprog_q <= 1'b1;
      else if (!v_hold && !v_settle)
        v_reprog_q <= 1'b0;
    end
  end

  clkroute_window #(.BASE(TMO_CYC)) u_vwin (
    .clk_i       (ref_clk_i),
    .rst_ni      (rst_ni),
    .kick_i      (v_kick),
    .long_i      (long_tmo_i),
    .settle_ok_i (v_settle_ok),
    .hold_o      (v_hold),
    .settle_o    (v_settle),
    .hold_done_o (v_commit)
  );

  assign v_fb   = v_settle || (v_hold && v_reprog_q);
  assign v_idx  = v_fb ? vfallback(fb_mclk_i) : vsel_decode(v_active_q, ext_s2_q);
  assign v_pick = VSRC_N'(1) << v_idx;
  assign v_srcs = {mclk_src_i, ref_clk_i, ext_clk_i, vclk2_i, vclk1_i, vclk0_i};

  clkroute_bbm_mux #(.N(VSRC_N)) u_vmux (
    .rst_ni (rst_ni),
    .clk_i  (v_srcs),
    .pick_i (v_pick),
    .en_o   (v_en),
    .clk_o  (v_mux)
  );

  // memory side: stand-in is always the reference
  clkroute_window #(.BASE(TMO_CYC)) u_mwin (
    .clk_i       (ref_clk_i),
    .rst_ni      (rst_ni),
    .kick_i      (mem_reprog_i),
    .long_i      (long_tmo_i),
    .settle_ok_i (1'b1),
    .hold_o      (m_hold),
    .settle_o    (m_settle),
    .hold_done_o (m_hold_done)
  );

  assign m_busy = m_hold || m_settle;
  assign m_idx  = !pd_sync ? MI_PD : (m_busy ? MI_REF : MI_MCLK);
  assign m_pick = MSRC_N'(1) << m_idx;
  assign m_srcs = {pdclk_i, ref_clk_i, mclk_src_i};

  clkroute_bbm_mux #(.N(MSRC_N)) u_mmux (
    .rst_ni (rst_ni),
    .clk_i  (m_srcs),
    .pick_i (m_pick),
    .en_o   (m_en),
    .clk_o  (m_mux)
  );

  // pad stage: enable first, then power-down forcing on video
  assign vclk_oe_o = oe_i;
  assign mclk_oe_o = oe_i;
  assign vclk_o    = oe_i && (!pd_ni || v_mux);
  assign mclk_o    = oe_i && m_mux;

endmodule

// File: rtl/clkroute_chk.sv
module clkroute_chk
  import clkroute_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              oe,
  input logic              pd_n,
  input logic              fb_mclk,
  input logic              vclk,
  input logic              vclk_oe,
  input logic              mclk,
  input logic              mclk_oe,
  input logic [VSRC_N-1:0] v_en,
  input logic [MSRC_N-1:0] m_en,
  input logic              v_commit,
  input logic [1:0]        v_active,
  input logic              v_settle,
  input logic [2:0]        v_idx,
  input logic              m_settle,
  input logic              m_hold_done,
  input logic              m_busy,
  input logic              pd_sync,
  input logic [1:0]        m_idx
);

  AST_VEN_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(v_en)); // R11
  AST_MEN_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(m_en)); // R11
  AST_SEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !v_commit |=> $stable(v_active)); // R3
  AST_SETTLE_AFTER_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(v_settle) |-> $past(v_commit)); // R4
  AST_STANDIN_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    v_settle |-> (v_idx == (fb_mclk ? VI_MCLK : VI_REF))); // R5
  AST_MEM_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(m_settle) |-> $past(m_hold_done)); // R8
  AST_MEM_STANDIN: assert property (@(posedge clk) disable iff (!rst_n)
    (m_busy && pd_sync) |-> (m_idx == MI_REF)); // R8
  AST_OE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |-> (!vclk_oe && !mclk_oe && !vclk && !mclk)); // R9
  AST_PD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (oe && !pd_n) |-> vclk); // R10
  AST_MEM_PD_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_sync |-> (m_idx == MI_PD)); // R10

endmodule

bind clock_output_router clkroute_chk u_chk (
  .clk         (ref_clk_i),
  .rst_n       (rst_ni),
  .oe          (oe_i),
  .pd_n        (pd_ni),
  .fb_mclk     (fb_mclk_i),
  .vclk        (vclk_o),
  .vclk_oe     (vclk_oe_o),
  .mclk        (mclk_o),
  .mclk_oe     (mclk_oe_o),
  .v_en        (v_en),
  .m_en        (m_en),
  .v_commit    (v_commit),
  .v_active    (v_active_q),
  .v_settle    (v_settle),
  .v_idx       (v_idx),
  .m_settle    (m_settle),
  .m_hold_done (m_hold_done),
  .m_busy      (m_busy),
  .pd_sync     (pd_sync),
  .m_idx       (m_idx)
);

// File: tb/clock_output_router_tb.sv
`timescale 1ns/1ps
module clock_output_router_tb;

  localparam int unsigned TMO = 100;   // 2000 ns per window at 20 ns
  localparam real WIN  = 1500.0;
  localparam real P_V0 = 14.0, P_V1 = 26.0, P_V2 = 34.0, P_EXT = 46.0;
  localparam real P_REF = 20.0, P_MC = 18.0, P_PD = 60.0;

  logic rst_n = 1'b0;
  logic ref_clk = 1'b0, v0 = 1'b0, v1 = 1'b0, v2 = 1'b0, ext = 1'b0, mc = 1'b0, pdc = 1'b0;
  logic [1:0] sel = 2'b00;
  logic extsel = 1'b0, oe = 1'b1, pd_n = 1'b1, long_tmo = 1'b0, fb_mclk = 1'b0;
  logic vrep = 1'b0, mrep = 1'b0;
  logic vclk, vclk_oe, mclk, mclk_oe;

  always #10 ref_clk = ~ref_clk;
  always #7  v0  = ~v0;
  always #13 v1  = ~v1;
  always #17 v2  = ~v2;
  always #23 ext = ~ext;
  always #9  mc  = ~mc;
  always #30 pdc = ~pdc;

  clock_output_router #(.TMO_CYC(TMO)) u_dut (
    .rst_ni(rst_n), .ref_clk_i(ref_clk), .vclk0_i(v0), .vclk1_i(v1), .vclk2_i(v2),
    .ext_clk_i(ext), .mclk_src_i(mc), .pdclk_i(pdc), .sel_i(sel), .extsel_i(extsel),
    .oe_i(oe), .pd_ni(pd_n), .long_tmo_i(long_tmo), .fb_mclk_i(fb_mclk),
    .vid_reprog_i(vrep), .mem_reprog_i(mrep),
    .vclk_o(vclk), .vclk_oe_o(vclk_oe), .mclk_o(mclk), .mclk_oe_o(mclk_oe)
  );

  int  n_run = 0, n_fail = 0;
  int  vcnt = 0, mcnt = 0;
  int  pw_bad = 0;
  bit  pw_on = 1'b0;
  real last_v = 0.0, last_m = 0.0;
  real t0;

  always @(posedge vclk) vcnt++;
  always @(posedge mclk) mcnt++;

  // pulse-width monitor (R11)
  always @(vclk) begin
    if (pw_on && ($realtime - last_v) < 6.5) pw_bad++;
    last_v = $realtime;
  end
  always @(mclk) begin
    if (pw_on && ($realtime - last_m) < 6.5) pw_bad++;
    last_m = $realtime;
  end

  task automatic check_bit(string tag, logic got, logic exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b", tag, got, exp);
    end
  endtask

  task automatic check_rate(string tag, int got, real per);
    int exp;
    exp = int'(WIN / per);
    n_run++;
    if (got < exp - 3 || got > exp + 3) begin
      n_fail++;
      $display("FAIL %s: got %0d edges expected %0d", tag, got, exp);
    end
  endtask

  task automatic wait_to(real off);
    real d;
    d = t0 + off - $realtime;
    if (d > 0.0) #(d);
  endtask

  task automatic measure(output int nv, output int nm);
    int a, b;
    a = vcnt; b = mcnt;
    #(WIN);
    nv = vcnt - a; nm = mcnt - b;
  endtask

  task automatic set_sel(logic [1:0] s);
    @(negedge ref_clk);
    sel = s;
    t0 = $realtime;
  endtask

  task automatic t_reset;
    int nv, nm;
    #95;
    check_bit("R1 video low in reset", vclk, 1'b0);
    check_bit("R1 memory low in reset", mclk, 1'b0);
    @(negedge ref_clk);
    rst_n = 1'b1;
    pw_on = 1'b1;
    #400;
    measure(nv, nm);
    check_rate("R1 video after reset = clk0", nv, P_V0);
    check_rate("R1 memory after reset = mclk", nm, P_MC);
  endtask

  task automatic settle_and_check(logic [1:0] s, string tag, real per);
    int nv, nm;
    set_sel(s);
    wait_to(4400.0);
    measure(nv, nm);
    check_rate(tag, nv, per);
  endtask

  task automatic t_decode;
    int nv, nm;
    settle_and_check(2'b01, "R2 code 01 -> clk1", P_V1);
    settle_and_check(2'b11, "R2 code 11 -> clk2", P_V2);
    settle_and_check(2'b10, "R2 code 10 extsel=0 -> ext", P_EXT);
    @(negedge ref_clk) extsel = 1'b1;
    #300;
    measure(nv, nm);
    check_rate("R2 code 10 extsel=1 -> clk2", nv, P_V2);
    @(negedge ref_clk) extsel = 1'b0;
    settle_and_check(2'b00, "R2 code 00 -> clk0", P_V0);
  endtask

  task automatic three_phase(logic [1:0] s, real p_old, real p_fb, real p_new,
                             real off_hold, real off_fb, real off_new, string tag);
    int nv, nm;
    set_sel(s);
    wait_to(off_hold);
    measure(nv, nm);
    check_rate({tag, " hold keeps old"}, nv, p_old);
    wait_to(off_fb);
    measure(nv, nm);
    check_rate({tag, " stand-in"}, nv, p_fb);
    wait_to(off_new);
    measure(nv, nm);
    check_rate({tag, " new source"}, nv, p_new);
  endtask

  task automatic t_defer;
    fb_mclk = 1'b0;
    three_phase(2'b01, P_V0, P_REF, P_V1, 200.0, 2400.0, 4400.0, "R3 R4 R5 ref");
    fb_mclk = 1'b1;
    three_phase(2'b00, P_V1, P_MC, P_V0, 200.0, 2400.0, 4400.0, "R3 R4 R5 mclk");
    fb_mclk = 1'b0;
  endtask

  task automatic t_burst;
    int nv, nm;
    @(negedge ref_clk);
    fork
      begin
        sel = 2'b11; #600;
        sel = 2'b01; #600;
        sel = 2'b00;
      end
    join_none
    measure(nv, nm);
    check_rate("R3 burst: clk0 kept during traffic", nv, P_V0);
    measure(nv, nm);
    check_rate("R3 burst: no stand-in after hold", nv, P_V0);
    measure(nv, nm);
    check_rate("R3 burst: clk0 kept afterwards", nv, P_V0);
  endtask

  task automatic t_long;
    int nv, nm;
    long_tmo = 1'b1;
    three_phase(2'b01, P_V0, P_REF, P_V1, 2400.0, 4400.0, 8400.0, "R6 doubled");
    long_tmo = 1'b0;
    settle_and_check(2'b00, "R6 back to clk0", P_V0);
  endtask

  task automatic pulse(ref logic p);
    @(negedge ref_clk);
    p = 1'b1;
    t0 = $realtime;
    @(negedge ref_clk);
    p = 1'b0;
  endtask

  task automatic t_vrep;
    int nv, nm;
    fb_mclk = 1'b1;
    pulse(vrep);
    wait_to(200.0);
    measure(nv, nm);
    check_rate("R7 stand-in in first window", nv, P_MC);
    wait_to(2400.0);
    measure(nv, nm);
    check_rate("R7 stand-in in second window", nv, P_MC);
    wait_to(4400.0);
    measure(nv, nm);
    check_rate("R7 register clock returns", nv, P_V0);
    fb_mclk = 1'b0;
  endtask

  task automatic t_mrep;
    int nv, nm;
    pulse(mrep);
    wait_to(200.0);
    measure(nv, nm);
    check_rate("R8 memory stand-in first window", nm, P_REF);
    check_rate("R8 video untouched", nv, P_V0);
    wait_to(2400.0);
    measure(nv, nm);
    check_rate("R8 memory stand-in second window", nm, P_REF);
    wait_to(4400.0);
    measure(nv, nm);
    check_rate("R8 memory clock returns", nm, P_MC);
  endtask

  task automatic t_oe;
    int nv, nm;
    pw_on = 1'b0;
    @(negedge ref_clk) oe = 1'b0;
    #50;
    check_bit("R9 video pad enable off", vclk_oe, 1'b0);
    check_bit("R9 memory pad enable off", mclk_oe, 1'b0);
    measure(nv, nm);
    check_rate("R9 no video edges", nv, 1.0e9);
    check_rate("R9 no memory edges", nm, 1.0e9);
    @(negedge ref_clk) oe = 1'b1;
    #300;
    pw_on = 1'b1;
    check_bit("R9 video pad enable on", vclk_oe, 1'b1);
    measure(nv, nm);
    check_rate("R9 video resumes clk0", nv, P_V0);
  endtask

  task automatic t_pd;
    int nv, nm;
    bit all_high;
    pw_on = 1'b0;
    @(negedge ref_clk) pd_n = 1'b0;
    #400;
    all_high = 1'b1;
    for (int i = 0; i < 20; i++) begin
      #37;
      if (vclk !== 1'b1) all_high = 1'b0;
    end
    check_bit("R10 video held high", all_high, 1'b1);
    measure(nv, nm);
    check_rate("R10 video has no edges", nv, 1.0e9);
    check_rate("R10 memory carries pd clock", nm, P_PD);
    @(negedge ref_clk) pd_n = 1'b1;
    #400;
    pw_on = 1'b1;
    measure(nv, nm);
    check_rate("R10 memory clock after wake", nm, P_MC);
  endtask

  task automatic finish_run;
    n_run++;
    if (pw_bad != 0) begin
      n_fail++;
      $display("FAIL R11 narrow pulses: got %0d expected 0", pw_bad);
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_decode();
    t_defer();
    t_burst();
    t_long();
    t_vrep();
    t_mrep();
    t_oe();
    t_pd();
    finish_run();
  end

endmodule